// File: doc/BRIEF.md
# Privileged Segment Address Decoder

This block sorts each 32-bit virtual address into one of five fixed segments and checks it against the privilege level of the access. It then takes one of three actions. It can form a physical address directly for the unmapped kernel windows and for the user segment while the error level is raised. It can hand the address to an external translation buffer. It can raise an address error.

The translation buffer answers later through a result port. A miss, an invalid entry or a write to a clean page is turned into an exception code. Whenever any fault is reported, the faulting address is latched into three capture registers: a bad-address register, a context word and an entry-high word. The context word combines a page-table base input with the faulting page number. The entry-high word combines the faulting page number with the current address-space identifier input.

Top module: `vseg_decoder`

## Requirements
- R1: With the error flag clear, an address at or below 0x7FFFFFFF raises `tlb_req` in the same cycle for every mode, with `tlb_vaddr` equal to the address. No direct mapping and no exception follow.
- R2: With the error flag set, an address at or below 0x7FFFFFFF gives `map_valid` one cycle later with `map_addr` equal to the address, and does not raise `tlb_req`.
- R3: In kernel mode (mode 00), an address in 0x80000000..0x9FFFFFFF gives `map_valid` one cycle later with `map_addr` equal to the address minus 0x80000000, and is never forwarded.
- R4: In kernel mode, an address in 0xA0000000..0xBFFFFFFF gives `map_valid` one cycle later with `map_addr` equal to the address minus 0xA0000000.
- R5: An address in 0xC0000000..0xDFFFFFFF is forwarded in kernel and supervisor mode (mode 01). In user mode it raises an address error.
- R6: An address in 0xE0000000..0xFFFFFFFF is forwarded only in kernel mode. Any other mode raises an address error.
- R7: An address error appears one cycle after the request as `exc_valid` with `exc_code` 4 for a load or 5 for a store, and with `exc_refill` low.
- R8: Mode 11 behaves exactly as user mode (10).
- R9: A translation result of 01 (no match) gives `exc_code` 2 for a load or 3 for a store, with `exc_refill` high. A result of 10 (invalid) gives the same codes with `exc_refill` low. The direction is the one of the last forwarded request.
- R10: A translation result of 11 (modify) gives `exc_code` 1 with `exc_refill` low, whatever the direction.
- R11: A translation result of 00 (hit) raises no exception.
- R12: On the cycle `exc_valid` is high, `bad_vaddr` holds the full faulting address. `ctx_out` holds `pt_base` in bits 31:23, the faulting address bits 31:13 in bits 22:4, and zero in bits 3:0. `ehi_out` holds the faulting address bits 31:13 in bits 31:13, zero in bits 12:8, and `cur_asid` in bits 7:0. All three are zero after reset, and the captured address does not change without a fault.
- R13: `exc_valid` is a one-cycle pulse for each fault, one cycle after the request or result that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | 32 | Virtual address of the access |
| req_mode | input | 2 | Privilege: 00 kernel, 01 supervisor, 10/11 user |
| req_erl | input | 1 | Error-level flag |
| req_store | input | 1 | 1 for a store, 0 for a load |
| cur_asid | input | 8 | Current address-space identifier |
| pt_base | input | 9 | Page-table base for the context word |
| tlb_res_valid | input | 1 | Translation result is present |
| tlb_res_kind | input | 2 | 00 hit, 01 no match, 10 invalid, 11 modify |
| tlb_req | output | 1 | Forward the current access for translation |
| tlb_vaddr | output | 32 | Address forwarded for translation |
| map_valid | output | 1 | Direct physical address is ready |
| map_addr | output | 32 | Direct physical address |
| exc_valid | output | 1 | Exception pulse |
| exc_code | output | 5 | Exception cause code |
| exc_refill | output | 1 | Exception is a translation miss needing refill |
| bad_vaddr | output | 32 | Captured faulting address |
| ctx_out | output | 32 | Captured context word |
| ehi_out | output | 32 | Captured entry-high word |

## Verification
The assertions assume that a translation result never arrives in the same cycle as a new request. They also assume that each result answers the most recent forwarded access and comes at least one cycle after it. The properties that describe request outcomes leave out cycles with a result present, because a result takes priority. The stimulus sends each request in its own cycle. When a request is forwarded, its result follows in the next cycle, and an idle cycle separates each group, so no overlap can occur.

// File: rtl/vseg_pkg.sv
package vseg_pkg;
  localparam int VA_W       = 32;
  localparam int PAGE_SHIFT = 13;
  localparam int ASID_W     = 8;
  localparam int CTX_LOW    = 4;
  localparam int VPN_W      = VA_W - PAGE_SHIFT;
  localparam int PTB_W      = VA_W - VPN_W - CTX_LOW;
  localparam int CODE_W     = 5;

  typedef enum logic [2:0] {
    REG_USEG, REG_KDIR0, REG_KDIR1, REG_SUPMAP, REG_KMAP
  } region_e;

  typedef enum logic [1:0] {
    ACT_NONE, ACT_DIRECT, ACT_FORWARD, ACT_ADDRERR
  } act_e;

  typedef enum logic [1:0] {
    TLB_HIT = 2'b00, TLB_MISS = 2'b01, TLB_INVAL = 2'b10, TLB_MOD = 2'b11
  } tlbres_e;

  localparam logic [CODE_W-1:0] CODE_MOD    = 5'd1;
  localparam logic [CODE_W-1:0] CODE_TLB_LD = 5'd2;
  localparam logic [CODE_W-1:0] CODE_TLB_ST = 5'd3;
  localparam logic [CODE_W-1:0] CODE_ADE_LD = 5'd4;
  localparam logic [CODE_W-1:0] CODE_ADE_ST = 5'd5;

  function automatic region_e region_of(input logic [VA_W-1:0] va);
    case (va[VA_W-1 -: 3])
      3'b100:  return REG_KDIR0;
      3'b101:  return REG_KDIR1;
      3'b110:  return REG_SUPMAP;
      3'b111:  return REG_KMAP;
      default: return REG_USEG;
    endcase
  endfunction

  function automatic logic [VA_W-1:0] strip_window(input logic [VA_W-1:0] va);
    return {3'b000, va[VA_W-4:0]};
  endfunction

  function automatic logic [VA_W-1:0] context_of(input logic [PTB_W-1:0] base,
                                                 input logic [VA_W-1:0] va);
    return {base, va[VA_W-1:PAGE_SHIFT], {CTX_LOW{1'b0}}};
  endfunction

  function automatic logic [VA_W-1:0] entryhi_of(input logic [VA_W-1:0] va,
                                                 input logic [ASID_W-1:0] asid);
    return {va[VA_W-1:PAGE_SHIFT], {(PAGE_SHIFT-ASID_W){1'b0}}, asid};
  endfunction
endpackage

// File: rtl/vseg_classify.sv
module vseg_classify
  import vseg_pkg::*;
(
  input  logic            valid,
  input  logic [VA_W-1:0] va,
  input  logic [1:0]      mode,
  input  logic            erl,
  output act_e            act,
  output logic [VA_W-1:0] phys
);
  logic is_kernel;
  logic is_super;

  assign is_kernel = (mode == 2'b00);
  assign is_super  = (mode == 2'b01);

  always_comb begin
    act  = ACT_FORWARD;
    phys = va;
    case (region_of(va))
      REG_USEG:   if (erl) act = ACT_DIRECT;
      REG_KDIR0,
      REG_KDIR1: begin
        if (is_kernel) begin
          act  = ACT_DIRECT;
          phys = strip_window(va);
        end else begin
          act = ACT_ADDRERR;
        end
      end
      REG_SUPMAP: act = (is_kernel || is_super) ? ACT_FORWARD : ACT_ADDRERR;
      REG_KMAP:   act = is_kernel ? ACT_FORWARD : ACT_ADDRERR;
      default:    act = ACT_ADDRERR;
    endcase
    if (!valid) act = ACT_NONE;
  end
endmodule

// File: rtl/vseg_tlb_fault.sv
module vseg_tlb_fault
  import vseg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fwd_fire,
  input  logic [VA_W-1:0]   fwd_va,
  input  logic              fwd_store,
  input  logic              res_valid,
  input  logic [1:0]        res_kind,
  output logic              flt_fire,
  output logic [CODE_W-1:0] flt_code,
  output logic              flt_refill,
  output logic [VA_W-1:0]   flt_va
);
  logic [VA_W-1:0] pend_va;
  logic            pend_store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_va    <= '0;
      pend_store <= 1'b0;
    end else if (fwd_fire) begin
      pend_va    <= fwd_va;
      pend_store <= fwd_store;
    end
  end

  always_comb begin
    flt_fire   = res_valid && (tlbres_e'(res_kind) != TLB_HIT);
    flt_refill = res_valid && (tlbres_e'(res_kind) == TLB_MISS);
    flt_va     = pend_va;
    case (tlbres_e'(res_kind))
      TLB_MOD: flt_code = CODE_MOD;
      default: flt_code = pend_store ? CODE_TLB_ST : CODE_TLB_LD;
    endcase
  end
endmodule

// File: rtl/vseg_capture.sv
module vseg_capture
  import vseg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  input  logic [PTB_W-1:0]  base,
  output logic [VA_W-1:0]   bad_va,
  output logic [VA_W-1:0]   ctx,
  output logic [VA_W-1:0]   ehi
);
  logic [VA_W-1:0] ctx_q;
  logic [VA_W-1:0] ehi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_va <= '0;
      ctx_q  <= '0;
      ehi_q  <= '0;
    end else if (take) begin
      bad_va <= va;
      ctx_q  <= context_of(base, va);
      ehi_q  <= entryhi_of(va, asid);
    end
  end

  assign ctx = ctx_q;
  assign ehi = ehi_q;

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(bad_va));
  assert_vpn_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (ehi_q[VA_W-1:PAGE_SHIFT] == bad_va[VA_W-1:PAGE_SHIFT]) &&
             (ctx_q[VA_W-PTB_W-1:CTX_LOW] == bad_va[VA_W-1:PAGE_SHIFT]));
endmodule

// File: rtl/vseg_decoder.sv
module vseg_decoder
  import vseg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [VA_W-1:0]   req_addr,
  input  logic [1:0]        req_mode,
  input  logic              req_erl,
  input  logic              req_store,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [PTB_W-1:0]  pt_base,
  input  logic              tlb_res_valid,
  input  logic [1:0]        tlb_res_kind,
  output logic              tlb_req,
  output logic [VA_W-1:0]   tlb_vaddr,
  output logic              map_valid,
  output logic [VA_W-1:0]   map_addr,
  output logic              exc_valid,
  output logic [CODE_W-1:0] exc_code,
  output logic              exc_refill,
  output logic [VA_W-1:0]   bad_vaddr,
  output logic [VA_W-1:0]   ctx_out,
  output logic [VA_W-1:0]   ehi_out
);
  act_e              act;
  logic [VA_W-1:0]   direct_pa;
  logic              flt_fire;
  logic [CODE_W-1:0] flt_code;
  logic              flt_refill;
  logic [VA_W-1:0]   flt_va;
  logic              addr_err;
  logic              exc_fire;
  logic [VA_W-1:0]   exc_va;
  logic [CODE_W-1:0] exc_code_d;

  vseg_classify u_classify (
    .valid (req_valid),
    .va    (req_addr),
    .mode  (req_mode),
    .erl   (req_erl),
    .act   (act),
    .phys  (direct_pa)
  );

  assign tlb_req   = (act == ACT_FORWARD);
  assign tlb_vaddr = req_addr;
  assign addr_err  = (act == ACT_ADDRERR);

  vseg_tlb_fault u_fault (
    .clk        (clk),
    .rst_n      (rst_n),
    .fwd_fire   (tlb_req),
    .fwd_va     (req_addr),
    .fwd_store  (req_store),
    .res_valid  (tlb_res_valid),
    .res_kind   (tlb_res_kind),
    .flt_fire   (flt_fire),
    .flt_code   (flt_code),
    .flt_refill (flt_refill),
    .flt_va     (flt_va)
  );

  // An outstanding translation fault wins over a new address error.
  assign exc_fire   = flt_fire || addr_err;
  assign exc_va     = flt_fire ? flt_va : req_addr;
  assign exc_code_d = flt_fire ? flt_code : (req_store ? CODE_ADE_ST : CODE_ADE_LD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_valid  <= 1'b0;
      map_addr   <= '0;
      exc_valid  <= 1'b0;
      exc_code   <= '0;
      exc_refill <= 1'b0;
    end else begin
      map_valid  <= (act == ACT_DIRECT);
      if (act == ACT_DIRECT) map_addr <= direct_pa;
      exc_valid  <= exc_fire;
      exc_code   <= exc_fire ? exc_code_d : '0;
      exc_refill <= flt_fire && flt_refill;
    end
  end

  vseg_capture u_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .take   (exc_fire),
    .va     (exc_va),
    .asid   (cur_asid),
    .base   (pt_base),
    .bad_va (bad_vaddr),
    .ctx    (ctx_out),
    .ehi    (ehi_out)
  );

  assert_user_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_erl && !req_addr[VA_W-1]) |-> tlb_req && (tlb_vaddr == req_addr));
  assert_erl_identity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_erl && !req_addr[VA_W-1] && !tlb_res_valid) |=>
      map_valid && (map_addr == $past(req_addr)) && !exc_valid);
  assert_no_fwd_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_req |-> (req_addr[VA_W-1:VA_W-2] != 2'b10));
  assert_kmap_kernel_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_req && req_mode != 2'b00) |-> (req_addr[VA_W-1:VA_W-3] != 3'b111));
  assert_user_window_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_mode[1] && req_addr[VA_W-1] && !tlb_res_valid) |=>
      exc_valid && !exc_refill &&
      (exc_code == ($past(req_store) ? CODE_ADE_ST : CODE_ADE_LD)));
  assert_refill_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_refill |-> exc_valid && (exc_code == CODE_TLB_LD || exc_code == CODE_TLB_ST));
  assert_modify_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_res_valid && tlb_res_kind == 2'b11) |=> exc_valid && (exc_code == CODE_MOD));
  assert_hit_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tlb_res_valid && tlb_res_kind == 2'b00 && !req_valid) |=> !exc_valid);
endmodule

// File: tb/test_vseg_decoder.sv
`timescale 1ns/1ps
module test_vseg_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_mode = '0;
  logic        req_erl = 1'b0;
  logic        req_store = 1'b0;
  logic [7:0]  cur_asid = 8'h5A;
  logic [8:0]  pt_base = 9'h133;
  logic        tlb_res_valid = 1'b0;
  logic [1:0]  tlb_res_kind = '0;
  logic        tlb_req;
  logic [31:0] tlb_vaddr;
  logic        map_valid;
  logic [31:0] map_addr;
  logic        exc_valid;
  logic [4:0]  exc_code;
  logic        exc_refill;
  logic [31:0] bad_vaddr;
  logic [31:0] ctx_out;
  logic [31:0] ehi_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] m_bad = '0;
  logic [31:0] m_ctx = '0;
  logic [31:0] m_ehi = '0;
  logic [31:0] m_pend = '0;
  logic        m_pst = 1'b0;

  always #2 clk = ~clk;

  vseg_decoder i_vseg_decoder (.*);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic note_fault(input logic [31:0] a);
    m_bad = a;
    m_ctx = ({23'd0, pt_base} << 23) | ((a >> 13) << 4);
    m_ehi = (a & 32'hFFFF_E000) | {24'd0, cur_asid};
  endtask

  task automatic chk_capture(input string rq);
    chk(rq, bad_vaddr, m_bad);
    chk(rq, ctx_out, m_ctx);
    chk(rq, ehi_out, m_ehi);
  endtask

  task automatic do_req(input logic [31:0] a, input logic [1:0] m,
                        input logic e, input logic s, output bit fwd);
    bit dir, err;
    logic [31:0] pa;
    string tg;
    bit kern, sup;
    kern = (m == 2'd0);
    sup  = (m == 2'd1);
    dir = 0; err = 0; fwd = 0; pa = a;
    if (a <= 32'h7FFF_FFFF) begin
      tg = e ? "R2" : "R1";
      if (e) dir = 1; else fwd = 1;
    end else if (a < 32'hA000_0000) begin
      tg = "R3";
      if (kern) begin dir = 1; pa = a - 32'h8000_0000; end else err = 1;
    end else if (a < 32'hC000_0000) begin
      tg = "R4";
      if (kern) begin dir = 1; pa = a - 32'hA000_0000; end else err = 1;
    end else if (a < 32'hE000_0000) begin
      tg = "R5";
      if (kern || sup) fwd = 1; else err = 1;
    end else begin
      tg = "R6";
      if (kern) fwd = 1; else err = 1;
    end
    if (m == 2'd3) tg = {tg, "/R8"};
    @(negedge clk);
    req_valid = 1; req_addr = a; req_mode = m; req_erl = e; req_store = s;
    #1;
    chk(tg, {31'd0, tlb_req}, {31'd0, fwd});
    if (fwd) chk(tg, tlb_vaddr, a);
    @(posedge clk);
    #1;
    req_valid = 0;
    chk(tg, {31'd0, map_valid}, {31'd0, dir});
    if (dir) chk(tg, map_addr, pa);
    chk(err ? "R7" : tg, {31'd0, exc_valid}, {31'd0, err});
    if (err) begin
      chk("R7", {27'd0, exc_code}, s ? 32'd5 : 32'd4);
      chk("R7", {31'd0, exc_refill}, 32'd0);
      note_fault(a);
    end
    chk_capture("R12");
    if (fwd) begin m_pend = a; m_pst = s; end
  endtask

  task automatic do_tlb(input logic [1:0] k);
    string tg;
    bit flt;
    logic [31:0] code;
    flt = (k != 2'd0);
    code = (k == 2'd3) ? 32'd1 : (m_pst ? 32'd3 : 32'd2);
    tg = (k == 2'd0) ? "R11" : (k == 2'd3) ? "R10" : "R9";
    @(negedge clk);
    tlb_res_valid = 1; tlb_res_kind = k;
    @(posedge clk);
    #1;
    tlb_res_valid = 0;
    chk(tg, {31'd0, exc_valid}, {31'd0, flt});
    if (flt) begin
      chk(tg, {27'd0, exc_code}, code);
      chk(tg, {31'd0, exc_refill}, {31'd0, (k == 2'd1)});
      note_fault(m_pend);
    end
    chk_capture("R12");
  endtask

  task automatic idle_check();
    @(negedge clk);
    @(posedge clk);
    #1;
    chk("R13", {31'd0, exc_valid}, 32'd0);
    chk("R12", bad_vaddr, m_bad);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] addrs [12];
    logic [1:0]  kinds;
    bit f;
    addrs = '{32'h0000_1234, 32'h7FFF_FFFF, 32'h8000_0000, 32'h9FFF_FFFF,
              32'hA000_0000, 32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
              32'hE000_0000, 32'hFFFF_FFFF, 32'h4567_89AB, 32'hB123_4567};
    kinds = 2'd0;
    repeat (3) @(negedge clk);
    chk("R12", bad_vaddr, 32'd0);
    chk("R12", ctx_out, 32'd0);
    chk("R12", ehi_out, 32'd0);
    chk("R13", {31'd0, exc_valid}, 32'd0);
    rst_n = 1;
    for (int i = 0; i < 12; i++) begin
      for (int m = 0; m < 4; m++) begin
        for (int e = 0; e < 2; e++) begin
          for (int s = 0; s < 2; s++) begin
            do_req(addrs[i], m[1:0], e[0], s[0], f);
            if (f) begin
              do_tlb(kinds);
              kinds = kinds + 2'd1;
            end
            idle_check();
          end
        end
      end
      if (i == 5) begin cur_asid = 8'hC3; pt_base = 9'h0A5; end
    end
    for (int n = 0; n < 200; n++) begin
      logic [31:0] r;
      logic [3:0]  mm;
      r  = $urandom;
      mm = 4'($urandom);
      do_req(r, mm[1:0], mm[2], mm[3], f);
      if (f) begin
        do_tlb(2'(n));
      end
      idle_check();
    end
    finish_run();
  end

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    finish_run();
  end
endmodule